// File: doc/BRIEF.md
# SECDED Codec with Read-Modify-Write Routing

This block protects 64-bit memory words with an extended Hamming code of eight check bits. The code corrects any one flipped bit in a stored word and detects any two. The write side is purely combinational. It takes a data word of up to 64 bits, pads any missing upper bits with zeros and returns a 72-bit codeword ready for storage.

The read side takes a 72-bit codeword from memory and registers its results. One clock later it returns the corrected 64-bit word, a single-error flag and a double-error flag. Every incoming read carries a tag. If the tag says the read was issued only to fetch old contents for a partial write, the result is signalled on a merge strobe and the user strobe stays low. The surrounding merge logic can then combine the old word with the new bytes. Otherwise the result is signalled on the user strobe. Both strobes share one data bus and one pair of flags.

Top module: `ecc_codec`

## Requirements
- R1: The write path outputs a 72-bit codeword in the same cycle as its input. Taken over all 72 bits, the codeword has even parity, and its 7-bit Hamming syndrome is zero.
- R2: With DATA_W below 64, input bit i maps to data bit i and data bits DATA_W..63 are encoded as zero. Decoding such a codeword returns zeros in those upper bits.
- R3: Codeword layout:
  - Bit 0 is the overall parity bit.
  - Bits 1, 2, 4, 8, 16, 32 and 64 are the Hamming check bits. Check bit 2^k is the even parity of every other position p in 1..71 whose binary index has bit k set.
  - Data bit d occupies the d-th position, counted from 0 in ascending order, among positions 3..71 that are not powers of two.
- R4: A read codeword with no errors returns its data with both flags low.
- R5: A read codeword with exactly one flipped bit, at any of the 72 positions, returns the original data with the single-error flag high and the double-error flag low. This holds even when the flipped bit is a check bit or the overall parity bit, and in those cases the data is unchanged.
- R6: A read codeword with exactly two flipped bits raises the double-error flag with the single-error flag low. The output data is then the data bits of the received codeword, uncorrected.
- R7: Read results appear exactly one clock edge after the codeword is presented with its valid input high. Data, flags and strobes are aligned in that cycle.
- R8: If the tag input is 0 with a valid read, the user strobe rises and the merge strobe stays low. If the tag is 1, the merge strobe rises, the user strobe stays low, and the same data and flags are returned.
- R9: While reset is held, both strobes, both flags and the read data are 0, whatever the inputs do.
- R10: In a cycle after one with the valid input low, both strobes and both flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | DATA_W (64) | Data word to be encoded |
| wr_code | output | 72 | Codeword for wr_data (combinational) |
| rd_valid_i | input | 1 | Read codeword present this cycle |
| rd_rmw_i | input | 1 | Tag: 1 = read serves a partial write |
| rd_code_i | input | 72 | Codeword read from memory |
| rd_data_o | output | 64 | Corrected (or raw on double error) data |
| rd_sbe_o | output | 1 | Single-bit error seen and corrected |
| rd_dbe_o | output | 1 | Double-bit error detected |
| usr_valid_o | output | 1 | Result belongs to the user |
| mrg_valid_o | output | 1 | Result belongs to the merge path |

## Verification
The assertions cover properties that hold on every cycle:
- the even parity of every encoded word;
- that the two flags are mutually exclusive, as are the two strobes;
- the one-cycle latency and routing of each strobe according to the tag;
- quiet outputs after idle cycles;
- that an even-parity codeword is never reported as a single error.

Only the bench scenarios can show the following:
- that the codeword layout matches the defined positions;
- that a flip at each of the 72 positions is corrected back to the original data;
- that double errors return the raw data bits;
- that a narrower write width really zero-fills the upper data bits.

// File: rtl/ecc_secded_pkg.sv
package ecc_secded_pkg;

   // Number of Hamming check bits needed for w data bits: smallest r with 2^r >= w + r + 1.
   function automatic int ham_bits(input int w);
      int r;
      r = 1;
      while ((1 << r) < (w + r + 1)) r++;
      return r;
   endfunction

   function automatic bit is_pow2(input int p);
      return (p != 0) && ((p & (p - 1)) == 0);
   endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
   parameter int WORD_W = 64,
   parameter int DATA_W = 64,
   localparam int HAM_W = ecc_secded_pkg::ham_bits(WORD_W),
   localparam int CODE_W = WORD_W + HAM_W + 1
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CODE_W-1:0] code_o
);
   import ecc_secded_pkg::*;

   logic [WORD_W-1:0] word;

   // Narrow inputs are padded with zeros above DATA_W.
   if (DATA_W == WORD_W) begin : g_full
      assign word = data_i;
   end else begin : g_pad
      assign word = {{(WORD_W-DATA_W){1'b0}}, data_i};
   end

   logic [CODE_W-1:0] cw;
   always_comb begin
      int d;
      logic x;
      cw = '0;
      d  = 0;
      // Scatter data over positions that are not powers of two.
      for (int p = 1; p < CODE_W; p++) begin
         if (!is_pow2(p)) begin
            cw[p] = word[d];
            d++;
         end
      end
      // Check bit 2^k covers every position whose index has bit k set.
      for (int k = 0; k < HAM_W; k++) begin
         x = 1'b0;
         for (int p = 1; p < CODE_W; p++) begin
            if ((((p >> k) & 1) == 1) && !is_pow2(p)) x = x ^ cw[p];
         end
         cw[1 << k] = x;
      end
      // Bit 0 makes the parity of the whole word even.
      cw[0] = ^cw[CODE_W-1:1];
   end

   assign code_o = cw;

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec #(
   parameter int WORD_W = 64,
   localparam int HAM_W = ecc_secded_pkg::ham_bits(WORD_W),
   localparam int CODE_W = WORD_W + HAM_W + 1
) (
   input  logic [CODE_W-1:0] code_i,
   output logic [WORD_W-1:0] data_o,
   output logic              sbe_o,
   output logic              dbe_o
);
   import ecc_secded_pkg::*;

   logic [HAM_W-1:0]  syn;
   logic              odd;
   logic              in_range;
   logic [CODE_W-1:0] fixed;

   always_comb begin
      logic x;
      for (int k = 0; k < HAM_W; k++) begin
         x = 1'b0;
         for (int p = 1; p < CODE_W; p++) begin
            if (((p >> k) & 1) == 1) x = x ^ code_i[p];
         end
         syn[k] = x;
      end
   end

   assign odd      = ^code_i;
   assign in_range = (int'(syn) < CODE_W);

   // Odd parity: one flip (syndrome 0 means bit 0 itself).
   // Even parity with a nonzero syndrome: two flips.
   // An odd-parity syndrome pointing past the word cannot be one flip.
   assign sbe_o = odd && in_range;
   assign dbe_o = (!odd && (syn != '0)) || (odd && !in_range);

   always_comb begin
      fixed = code_i;
      if (sbe_o) begin
         for (int p = 1; p < CODE_W; p++) begin
            if (p == int'(syn)) fixed[p] = ~code_i[p];
         end
      end
   end

   always_comb begin
      int d;
      d = 0;
      data_o = '0;
      for (int p = 1; p < CODE_W; p++) begin
         if (!is_pow2(p)) begin
            data_o[d] = fixed[p];
            d++;
         end
      end
   end

endmodule

// File: rtl/ecc_codec.sv
module ecc_codec #(
   parameter int WORD_W = 64,
   parameter int DATA_W = 64,
   localparam int HAM_W = ecc_secded_pkg::ham_bits(WORD_W),
   localparam int CODE_W = WORD_W + HAM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CODE_W-1:0] wr_code,
   input  logic              rd_valid_i,
   input  logic              rd_rmw_i,
   input  logic [CODE_W-1:0] rd_code_i,
   output logic [WORD_W-1:0] rd_data_o,
   output logic              rd_sbe_o,
   output logic              rd_dbe_o,
   output logic              usr_valid_o,
   output logic              mrg_valid_o
);

   if (DATA_W < 1 || DATA_W > WORD_W) begin : g_bad_data_w
      $error("ecc_codec: DATA_W must lie in 1..WORD_W");
   end
   if (WORD_W < 4) begin : g_bad_word_w
      $error("ecc_codec: WORD_W too small for SECDED");
   end

   ecc_enc #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_enc (
      .data_i (wr_data),
      .code_o (wr_code)
   );

   logic [WORD_W-1:0] dec_data;
   logic              dec_sbe;
   logic              dec_dbe;

   ecc_dec #(.WORD_W(WORD_W)) u_dec (
      .code_i (rd_code_i),
      .data_o (dec_data),
      .sbe_o  (dec_sbe),
      .dbe_o  (dec_dbe)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o   <= '0;
         rd_sbe_o    <= 1'b0;
         rd_dbe_o    <= 1'b0;
         usr_valid_o <= 1'b0;
         mrg_valid_o <= 1'b0;
      end else begin
         usr_valid_o <= rd_valid_i && !rd_rmw_i;
         mrg_valid_o <= rd_valid_i && rd_rmw_i;
         rd_sbe_o    <= rd_valid_i && dec_sbe;
         rd_dbe_o    <= rd_valid_i && dec_dbe;
         if (rd_valid_i) rd_data_o <= dec_data;
      end
   end

endmodule

// File: rtl/ecc_codec_chk.sv
module ecc_codec_chk #(
   parameter int WORD_W = 64,
   parameter int CODE_W = 72
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] wr_code,
   input logic              rd_valid_i,
   input logic              rd_rmw_i,
   input logic [CODE_W-1:0] rd_code_i,
   input logic              rd_sbe_o,
   input logic              rd_dbe_o,
   input logic              usr_valid_o,
   input logic              mrg_valid_o
);

   AST_WR_EVEN_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
      (^wr_code) == 1'b0); // R1

   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_sbe_o && rd_dbe_o)); // R6

   AST_ROUTE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(usr_valid_o && mrg_valid_o)); // R8

   AST_USER_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_i && !rd_rmw_i) |=> usr_valid_o); // R7

   AST_MERGE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_i && rd_rmw_i) |=> (mrg_valid_o && !usr_valid_o)); // R8

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid_i |=> (!usr_valid_o && !mrg_valid_o && !rd_sbe_o && !rd_dbe_o)); // R10

   AST_EVEN_NOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_i && ((^rd_code_i) == 1'b0)) |=> !rd_sbe_o); // R5

endmodule

bind ecc_codec ecc_codec_chk #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_code     (wr_code),
   .rd_valid_i  (rd_valid_i),
   .rd_rmw_i    (rd_rmw_i),
   .rd_code_i   (rd_code_i),
   .rd_sbe_o    (rd_sbe_o),
   .rd_dbe_o    (rd_dbe_o),
   .usr_valid_o (usr_valid_o),
   .mrg_valid_o (mrg_valid_o)
);

// File: tb/sim_ecc_codec.sv
module sim_ecc_codec;
   localparam int W  = 64;
   localparam int CW = 72;
   localparam int NW = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [W-1:0]  wr_data = '0;
   logic [CW-1:0] wr_code;
   logic          rd_valid = 1'b0, rd_rmw = 1'b0;
   logic [CW-1:0] rd_code = '0;
   logic [W-1:0]  rd_data;
   logic          sbe, dbe, usr_v, mrg_v;

   ecc_codec #(.WORD_W(W), .DATA_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code),
      .rd_valid_i(rd_valid), .rd_rmw_i(rd_rmw), .rd_code_i(rd_code),
      .rd_data_o(rd_data), .rd_sbe_o(sbe), .rd_dbe_o(dbe),
      .usr_valid_o(usr_v), .mrg_valid_o(mrg_v));

   // Narrow-width instance, write path only.
   logic [NW-1:0] wr_n = '0;
   logic [CW-1:0] wr_code_n;
   logic [W-1:0]  n_data;
   logic          n_sbe, n_dbe, n_usr, n_mrg;

   ecc_codec #(.WORD_W(W), .DATA_W(NW)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_n), .wr_code(wr_code_n),
      .rd_valid_i(1'b0), .rd_rmw_i(1'b0), .rd_code_i('0),
      .rd_data_o(n_data), .rd_sbe_o(n_sbe), .rd_dbe_o(n_dbe),
      .usr_valid_o(n_usr), .mrg_valid_o(n_mrg));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct {
      bit          usr;
      bit          mrg;
      logic [63:0] data;
      bit          sbe;
      bit          dbe;
      string       req;
   } exp_t;
   exp_t q[$];

   function automatic bit is_p2(input int p);
      return (p != 0) && ((p & (p - 1)) == 0);
   endfunction

   // Codeword as defined by the layout requirement.
   function automatic logic [71:0] ref_enc(input logic [63:0] d);
      logic [71:0] c;
      int idx;
      bit x;
      c = '0;
      idx = 0;
      for (int p = 1; p < 72; p++) if (!is_p2(p)) begin c[p] = d[idx]; idx++; end
      for (int k = 0; k < 7; k++) begin
         x = 0;
         for (int p = 1; p < 72; p++) if ((((p >> k) & 1) == 1) && !is_p2(p)) x ^= c[p];
         c[1 << k] = x;
      end
      c[0] = ^c[71:1];
      return c;
   endfunction

   function automatic logic [63:0] ref_raw(input logic [71:0] c);
      logic [63:0] d;
      int idx;
      d = '0;
      idx = 0;
      for (int p = 1; p < 72; p++) if (!is_p2(p)) begin d[idx] = c[p]; idx++; end
      return d;
   endfunction

   task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic compare_out();
      exp_t e;
      if (q.size() == 0) return;
      e = q.pop_front();
      check({e.req, " R7 R8 strobes"}, {70'd0, usr_v, mrg_v}, {70'd0, e.usr, e.mrg});
      if (e.usr || e.mrg) begin
         check({e.req, " data"}, {8'd0, rd_data}, {8'd0, e.data});
         check({e.req, " flags"}, {70'd0, sbe, dbe}, {70'd0, e.sbe, e.dbe});
      end else begin
         check("R10 idle flags", {70'd0, sbe, dbe}, 72'd0);
      end
   endtask

   // One clock: check last result, drive next read, check write path.
   task automatic cycle(input bit v, input bit tag, input logic [63:0] wd,
                        input logic [71:0] code, input logic [63:0] edata,
                        input bit esbe, input bit edbe, input string req);
      exp_t e;
      @(negedge clk);
      compare_out();
      rd_valid = v;
      rd_rmw   = tag;
      rd_code  = code;
      wr_data  = wd;
      wr_n     = wd[NW-1:0];
      e.usr = v && !tag;
      e.mrg = v && tag;
      e.data = edata;
      e.sbe = esbe;
      e.dbe = edbe;
      e.req = req;
      q.push_back(e);
      #1;
      check("R1 R3 encode", wr_code, ref_enc(wd));
      check("R2 zero fill encode", wr_code_n, ref_enc({24'd0, wd[NW-1:0]}));
   endtask

   initial begin
      logic [63:0] d;
      logic [71:0] c;
      int j;
      // Reset state, with read inputs active during reset.
      rd_valid = 1'b1;
      rd_code  = ref_enc(64'h1234_5678_9abc_def0);
      repeat (3) @(negedge clk);
      check("R9 reset strobes", {70'd0, usr_v, mrg_v}, 72'd0);
      check("R9 reset flags", {70'd0, sbe, dbe}, 72'd0);
      check("R9 reset data", {8'd0, rd_data}, 72'd0);
      rd_valid = 1'b0;
      rst_n = 1'b1;

      // R4 clean words, alternating tag (R8).
      for (int i = 0; i < 12; i++) begin
         d = (i == 0) ? 64'd0 : (i == 1) ? '1 : {$urandom, $urandom};
         cycle(1, i[0], d, ref_enc(d), d, 0, 0, "R4 clean");
      end
      cycle(0, 0, 64'd0, '0, '0, 0, 0, "R10 idle");

      // R5 one flip at each of the 72 positions.
      for (int i = 0; i < 72; i++) begin
         d = {$urandom, $urandom};
         c = ref_enc(d);
         c[i] = ~c[i];
         cycle(1, (i % 3) == 0, d, c, d, 1, 0, "R5 single");
         if ((i % 10) == 9) cycle(0, 1, d, c, '0, 0, 0, "R10 idle");
      end

      // R6 two flips.
      for (int i = 0; i < 60; i++) begin
         d = {$urandom, $urandom};
         c = ref_enc(d);
         j = (i * 7 + 5) % 72;
         if (j == (i % 72)) j = (j + 1) % 72;
         c[i % 72] = ~c[i % 72];
         c[j] = ~c[j];
         cycle(1, i[0], d, c, ref_raw(c), 0, 1, "R6 double");
      end

      // R2 narrow codeword read back: upper data bits zero.
      for (int i = 0; i < 6; i++) begin
         d = {$urandom, $urandom};
         wr_n = d[NW-1:0];
         #1;
         cycle(1, 0, d, wr_code_n, {24'd0, d[NW-1:0]}, 0, 0, "R2 narrow decode");
      end

      // Drain.
      for (int i = 0; i < 3; i++) cycle(0, 0, 64'd0, '0, '0, 0, 0, "R10 idle");
      @(negedge clk);
      compare_out();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL R7 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule